// File: doc/BRIEF.md
# Page Write Cache and Flush Sequencer

This block sits between a serial-bus slave and a nonvolatile byte array. It holds a 64-byte write cache, arranged as 8 cache pages of 8 bytes each. When a write command opens, the slave gives the block the command's start address. Each data byte that follows is stored at a cache pointer. The pointer starts in cache page 0, at the byte offset taken from the low address bits. It advances one byte per data byte and wraps from the end of the cache back to its start, so a burst longer than the cache overwrites earlier bytes. A valid flag is kept for every cache byte.

Nothing reaches the array while bytes are being loaded. When the slave reports Stop, the block raises `busy` and walks the cache pages in order. Cache page p goes to the array page that follows the command's page by p places, wrapping at the top of the array. The block first asks the security unit whether that array page is locked. A page that holds loaded bytes and is not locked is written with a single page-write strobe. The byte enables mark exactly the loaded bytes. A timed write cycle of `PAGE_CYCLES` clocks follows each such strobe. Pages that are empty or locked are passed over in one clock, and no error is raised. When the last page is done, all valid flags are cleared and `busy` falls. While `busy` is high, every load-port input is ignored, so the slave cannot start a new command.

Top module: `wcache_top`

## Requirements
- R1: After reset, `busy` and `arr_wr` are 0 and no cache byte is valid.
- R2: The first data byte of a command is stored in cache page 0 at offset `ld_addr[2:0]`. At flush, cache page 0 is written to the array page whose address is `{ld_addr[12:3], 3'b000}`. Byte offset k appears at `arr_data[8k+7:8k]` and is enabled by `arr_be[k]`.
- R3: Each data byte advances the cache pointer by one. Cache page p is written to array page `ld_addr[12:3] + p`, taken modulo 1024, so the flush continues across row and block boundaries.
- R4: After cache index 63 the pointer wraps to index 0. Later bytes overwrite earlier ones, so the tail of an unaligned burst is written together with cache page 0.
- R5: `arr_wr` is never asserted while bytes are being loaded. It is asserted only while `busy` is high.
- R6: Only loaded bytes are enabled in `arr_be`. A cache page with no loaded bytes gets no `arr_wr` and costs one clock.
- R7: `busy` rises on the clock after an accepted Stop that has loaded bytes. It stays high for (1 + `PAGE_CYCLES`) clocks per written page plus one clock per passed-over page. Two `arr_wr` strobes are at least `PAGE_CYCLES` clocks apart.
- R8: The page under flush is presented on `wp_query_addr`. When `wp_locked` is 1 for that page, it is not written. The other pages of the same command are still written.
- R9: A Stop with no loaded bytes leaves `busy` low and causes no write.
- R10: `ld_abort` during loading discards the loaded bytes. A later Stop then writes nothing.
- R11: While `busy` is high, `ld_begin`, `ld_valid` and `ld_stop` have no effect: the bytes are not written later and no second flush occurs.
- R12: Valid flags are clear after a flush. The next command writes only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_begin | input | 1 | Write command opens; captures `ld_addr` |
| ld_addr | input | ADDR_W | Start address of the write command |
| ld_valid | input | 1 | One data byte is present on `ld_data` |
| ld_data | input | 8 | Data byte |
| ld_stop | input | 1 | Stop received; start the flush |
| ld_abort | input | 1 | Command abandoned; discard loaded bytes |
| wp_query_addr | output | ADDR_W | Page-aligned array address now under flush |
| wp_locked | input | 1 | Security answer: queried page is write-protected |
| arr_wr | output | 1 | One-clock page-write strobe |
| arr_addr | output | ADDR_W | Page-aligned array address for `arr_wr` |
| arr_be | output | PAGE_BYTES | Byte enables for the page write |
| arr_data | output | 8*PAGE_BYTES | Page data, byte k at bits 8k+7:8k |
| busy | output | 1 | Flush in progress; load port ignored |

## Verification
A wrong cache pointer or base page shows up on the first `arr_wr` after Stop, as a wrong address, a shifted enable pattern or misplaced data bytes. A wrong valid flag shows up as a stray enable bit, or as a write to a page that should have been passed over. A fault in the sequencer's page counter or timer changes the length of `busy`, which the bench counts clock by clock from Stop. Stale flags left over from an earlier flush appear in the very next command's enables.

// File: rtl/wcache_pkg.sv
// Shared types for the page write cache.
package wcache_pkg;
    // Sequencer states: idle, loading bytes, scanning a page, waiting out a page write
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SCAN = 2'd2,
        ST_WAIT = 2'd3
    } wc_state_e;
endpackage

// File: rtl/wcache_store.sv
// Byte storage of the write cache with a valid flag per byte.
// Assumes PAGE_BYTES and NUM_PAGES are powers of two. Reads out one whole
// page, selected by rd_page, for the flush.
module wcache_store #(
    parameter int PAGE_BYTES = 8,
    parameter int NUM_PAGES  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0] wr_idx,
    input  logic [7:0]                         wr_byte,
    input  logic                               clr,
    input  logic [$clog2(NUM_PAGES)-1:0]       rd_page,
    output logic [8*PAGE_BYTES-1:0]            rd_data,
    output logic [PAGE_BYTES-1:0]              rd_valid,
    output logic                               any_valid
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int NBYTES = PAGE_BYTES * NUM_PAGES;

    logic [7:0]        mem [NBYTES];
    logic [NBYTES-1:0] valid;

    // Valid flags: cleared on reset, command start or flush end; set per written byte
    always_ff @(posedge clk) begin
        if (!rst_n)     valid <= '0;
        else if (clr)   valid <= '0;
        else if (wr_en) valid[wr_idx] <= 1'b1;
    end

    // Data bytes: written in place, no reset needed since valid gates use
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_byte;
    end

    // Page read-out, one lane per byte offset
    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_lane
        localparam logic [OFF_W-1:0] BO = OFF_W'(b);
        assign rd_data[8*b +: 8] = mem[{rd_page, BO}];
        assign rd_valid[b]       = valid[{rd_page, BO}];
    end

    assign any_valid = |valid;
endmodule

// File: rtl/wcache_timer.sv
// Page write cycle timer. A start pulse begins a window of PAGE_CYCLES
// clocks; done is high in the last clock of that window. PAGE_CYCLES >= 1.
module wcache_timer #(
    parameter int PAGE_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(PAGE_CYCLES + 1);

    logic             run;
    logic [CNT_W-1:0] cnt;

    // Countdown from PAGE_CYCLES-1 to zero while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CNT_W'(PAGE_CYCLES - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/wcache_ctrl.sv
// Load pointer and flush sequencer. Captures the command's page and offset,
// steers data bytes into the cache, and on Stop walks the cache pages,
// issuing one array write per loaded, unlocked page. Input priority while
// loading: begin, abort, stop, data byte.
module wcache_ctrl
    import wcache_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 8,
    parameter int NUM_PAGES  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_begin,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic                          ld_valid,
    input  logic                          ld_stop,
    input  logic                          ld_abort,
    input  logic                          any_valid,
    input  logic                          page_any,
    input  logic                          wp_locked,
    input  logic                          tmr_done,
    output logic                          wr_en,
    output logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0] wr_idx,
    output logic                          clr,
    output logic [$clog2(NUM_PAGES)-1:0]  rd_page,
    output logic                          tmr_start,
    output logic                          arr_wr,
    output logic [ADDR_W-1:0]             page_addr,
    output logic                          busy
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = $clog2(NUM_PAGES);
    localparam int IDX_W = PG_W + OFF_W;
    localparam int PN_W  = ADDR_W - OFF_W;

    wc_state_e        st;
    logic [IDX_W-1:0] ptr;
    logic [PN_W-1:0]  base_pn;
    logic [PG_W-1:0]  pg;
    logic             last_pg;
    logic             accept_begin;
    logic             do_write;
    logic             flush_end;

    // Decode of the current cycle's actions
    always_comb begin
        last_pg      = (pg == PG_W'(NUM_PAGES - 1));
        accept_begin = ld_begin && (st == ST_IDLE || st == ST_LOAD);
        do_write     = (st == ST_SCAN) && page_any && !wp_locked;
        flush_end    = ((st == ST_SCAN) && !do_write && last_pg) ||
                       ((st == ST_WAIT) && tmr_done && last_pg);
        wr_en        = (st == ST_LOAD) && ld_valid && !ld_begin && !ld_abort && !ld_stop;
        wr_idx       = ptr;
        clr          = accept_begin || ((st == ST_LOAD) && ld_abort && !ld_begin) || flush_end;
        rd_page      = pg;
        tmr_start    = do_write;
        arr_wr       = do_write;
        page_addr    = {base_pn + PN_W'(pg), {OFF_W{1'b0}}};
        busy         = (st == ST_SCAN) || (st == ST_WAIT);
    end

    // State, pointer, base page and page counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ptr     <= '0;
            base_pn <= '0;
            pg      <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (ld_begin) begin
                        st      <= ST_LOAD;
                        base_pn <= ld_addr[ADDR_W-1:OFF_W];
                        ptr     <= {{PG_W{1'b0}}, ld_addr[OFF_W-1:0]};
                    end
                end
                ST_LOAD: begin
                    if (ld_begin) begin
                        base_pn <= ld_addr[ADDR_W-1:OFF_W];
                        ptr     <= {{PG_W{1'b0}}, ld_addr[OFF_W-1:0]};
                    end else if (ld_abort) begin
                        st <= ST_IDLE;
                    end else if (ld_stop) begin
                        st <= any_valid ? ST_SCAN : ST_IDLE;
                        pg <= '0;
                    end else if (ld_valid) begin
                        ptr <= ptr + 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (do_write)     st <= ST_WAIT;
                    else if (last_pg) st <= ST_IDLE;
                    else              pg <= pg + 1'b1;
                end
                default: begin
                    if (tmr_done) begin
                        if (last_pg) st <= ST_IDLE;
                        else begin
                            pg <= pg + 1'b1;
                            st <= ST_SCAN;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/wcache_top.sv
// Page write cache top: cache storage, flush sequencer and page timer.
// Assumes protection granules are whole pages, so one query per page is
// enough, and that load inputs arrive already synchronised to clk.
module wcache_top #(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BYTES  = 8,
    parameter int NUM_PAGES   = 8,
    parameter int PAGE_CYCLES = 1250000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_begin,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic                    ld_valid,
    input  logic [7:0]              ld_data,
    input  logic                    ld_stop,
    input  logic                    ld_abort,
    output logic [ADDR_W-1:0]       wp_query_addr,
    input  logic                    wp_locked,
    output logic                    arr_wr,
    output logic [ADDR_W-1:0]       arr_addr,
    output logic [PAGE_BYTES-1:0]   arr_be,
    output logic [8*PAGE_BYTES-1:0] arr_data,
    output logic                    busy
);
    localparam int PG_W  = $clog2(NUM_PAGES);
    localparam int IDX_W = $clog2(PAGE_BYTES * NUM_PAGES);

    logic                  wr_en;
    logic [IDX_W-1:0]      wr_idx;
    logic                  clr;
    logic [PG_W-1:0]       rd_page;
    logic [PAGE_BYTES-1:0] rd_valid;
    logic                  any_valid;
    logic                  tmr_start;
    logic                  tmr_done;
    logic [ADDR_W-1:0]     page_addr;

    wcache_store #(
        .PAGE_BYTES(PAGE_BYTES),
        .NUM_PAGES (NUM_PAGES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_byte  (ld_data),
        .clr      (clr),
        .rd_page  (rd_page),
        .rd_data  (arr_data),
        .rd_valid (rd_valid),
        .any_valid(any_valid)
    );

    wcache_ctrl #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES),
        .NUM_PAGES (NUM_PAGES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_begin (ld_begin),
        .ld_addr  (ld_addr),
        .ld_valid (ld_valid),
        .ld_stop  (ld_stop),
        .ld_abort (ld_abort),
        .any_valid(any_valid),
        .page_any (|rd_valid),
        .wp_locked(wp_locked),
        .tmr_done (tmr_done),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .clr      (clr),
        .rd_page  (rd_page),
        .tmr_start(tmr_start),
        .arr_wr   (arr_wr),
        .page_addr(page_addr),
        .busy     (busy)
    );

    wcache_timer #(
        .PAGE_CYCLES(PAGE_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_start),
        .done (tmr_done)
    );

    // Both the security query and the array write use the page under flush
    assign wp_query_addr = page_addr;
    assign arr_addr      = page_addr;
    assign arr_be        = rd_valid;
endmodule

// File: rtl/wcache_chk.sv
// Port-level checker for wcache_top, attached by bind below. The write
// spacing window is measured with a saturating counter.
module wcache_chk #(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BYTES  = 8,
    parameter int PAGE_CYCLES = 1250000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ld_stop,
    input logic                  busy,
    input logic                  arr_wr,
    input logic [ADDR_W-1:0]     arr_addr,
    input logic [PAGE_BYTES-1:0] arr_be,
    input logic [ADDR_W-1:0]     wp_query_addr,
    input logic                  wp_locked
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [31:0] gap;

    // Clocks since the last page write, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                gap <= 32'hFFFF_FFFF;
        else if (arr_wr)           gap <= '0;
        else if (gap != 32'hFFFF_FFFF) gap <= gap + 1'b1;
    end

    // R5
    wr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |-> busy);

    // R6
    wr_has_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |-> (arr_be != '0));

    // R7
    wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |-> (gap >= 32'(PAGE_CYCLES)));

    // R7
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ld_stop));

    // R8
    wr_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |-> (!wp_locked && arr_addr == wp_query_addr));

    // R2
    wr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |-> (arr_addr[OFF_W-1:0] == '0));
endmodule

bind wcache_top wcache_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_CYCLES(PAGE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_stop      (ld_stop),
    .busy         (busy),
    .arr_wr       (arr_wr),
    .arr_addr     (arr_addr),
    .arr_be       (arr_be),
    .wp_query_addr(wp_query_addr),
    .wp_locked    (wp_locked)
);

// File: tb/sim_wcache_top.sv
// Scoreboard bench: the driver models the cache from the requirements and
// queues the expected page writes; the monitor compares each arr_wr.
module sim_wcache_top;
    localparam int PC = 12;

    typedef struct packed {
        logic [12:0] addr;
        logic [7:0]  be;
        logic [63:0] data;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_begin = 1'b0, ld_valid = 1'b0, ld_stop = 1'b0, ld_abort = 1'b0;
    logic [12:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [12:0] wp_query_addr, arr_addr;
    logic        wp_locked, arr_wr, busy;
    logic [7:0]  arr_be;
    logic [63:0] arr_data;

    logic        lock_en = 1'b0;
    logic [12:0] lock_lo = '0, lock_hi = '0;
    bit          loading = 1'b0;
    string       cur_tag = "R1";
    int          checks = 0, errors = 0;
    wr_item_t    exp_q[$];

    always #2 clk = ~clk;

    assign wp_locked = lock_en && (wp_query_addr >= lock_lo) && (wp_query_addr < lock_hi);

    wcache_top #(.ADDR_W(13), .PAGE_BYTES(8), .NUM_PAGES(8), .PAGE_CYCLES(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_begin(ld_begin), .ld_addr(ld_addr),
        .ld_valid(ld_valid), .ld_data(ld_data), .ld_stop(ld_stop), .ld_abort(ld_abort),
        .wp_query_addr(wp_query_addr), .wp_locked(wp_locked), .arr_wr(arr_wr),
        .arr_addr(arr_addr), .arr_be(arr_be), .arr_data(arr_data), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit locked_at(input logic [12:0] a);
        return lock_en && (a >= lock_lo) && (a < lock_hi);
    endfunction

    // Monitor: compare each page write with the head of the expected queue
    always @(negedge clk) begin
        if (rst_n && arr_wr) begin
            if (loading) begin
                chk(1'b0, "R5 write during load", 64'(arr_addr), 64'hFFFF);
            end else if (exp_q.size() == 0) begin
                chk(1'b0, {cur_tag, " unexpected write"}, 64'(arr_addr), 64'hFFFF);
            end else begin
                wr_item_t e;
                logic [63:0] m;
                e = exp_q.pop_front();
                m = '0;
                for (int b = 0; b < 8; b++) if (e.be[b]) m[8*b +: 8] = 8'hFF;
                chk(arr_addr == e.addr, {cur_tag, " addr"}, 64'(arr_addr), 64'(e.addr));
                chk(arr_be == e.be, {cur_tag, " be"}, 64'(arr_be), 64'(e.be));
                chk((arr_data & m) == (e.data & m), {cur_tag, " data"}, arr_data & m, e.data & m);
            end
        end
    end

    // Count busy clocks after the stop has been driven
    task automatic measure_busy(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (!busy || n > 5000) break;
            n++;
        end
    endtask

    // Driver: model the cache, queue expected writes, drive one command
    task automatic run_cmd(input logic [12:0] a, input int n, input int seed, input string tag);
        logic [7:0] cdat[64];
        bit         cval[64];
        int         idx, exp_busy, got_busy;
        cur_tag = tag;
        for (int i = 0; i < 64; i++) begin cval[i] = 0; cdat[i] = '0; end
        idx = int'(a[2:0]);
        for (int j = 0; j < n; j++) begin
            cdat[idx] = 8'((seed + j * 37) & 255);
            cval[idx] = 1;
            idx = (idx + 1) % 64;
        end
        exp_busy = 0;
        for (int p = 0; p < 8; p++) begin
            wr_item_t it;
            it.be = '0; it.data = '0;
            it.addr = {10'(a[12:3] + 10'(p)), 3'b000};
            for (int b = 0; b < 8; b++)
                if (cval[p*8+b]) begin it.be[b] = 1'b1; it.data[8*b +: 8] = cdat[p*8+b]; end
            if (it.be != 0 && !locked_at(it.addr)) begin
                exp_q.push_back(it);
                exp_busy += PC + 1;
            end else begin
                exp_busy += 1;
            end
        end
        if (n == 0) exp_busy = 0;
        @(posedge clk); #1;
        loading = 1; ld_begin = 1; ld_addr = a;
        @(posedge clk); #1;
        ld_begin = 0;
        for (int j = 0; j < n; j++) begin
            ld_valid = 1; ld_data = 8'((seed + j * 37) & 255);
            @(posedge clk); #1;
        end
        ld_valid = 0;
        chk(busy == 0, "R5 busy low while loading", 64'(busy), 0);
        loading = 0; ld_stop = 1;
        @(posedge clk); #1;
        ld_stop = 0;
        measure_busy(got_busy);
        chk(got_busy == exp_busy, {tag, " busy length R7"}, 64'(got_busy), 64'(exp_busy));
        chk(exp_q.size() == 0, {tag, " writes missing"}, 64'(exp_q.size()), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nb;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(busy == 0, "R1 busy", 64'(busy), 0);
        chk(arr_wr == 0, "R1 arr_wr", 64'(arr_wr), 0);
        // R1: a Stop right after reset finds no valid bytes
        run_cmd(13'h0040, 0, 0, "R1");

        run_cmd(13'h0123, 1, 5, "R2");
        run_cmd(13'h0206, 12, 9, "R3");
        run_cmd(13'h0200, 3, 1, "R6");
        run_cmd(13'h1FFA, 66, 77, "R4");
        run_cmd(13'h1FF8, 64, 200, "R3 wrap");

        lock_en = 1; lock_lo = 13'h0408; lock_hi = 13'h0410;
        run_cmd(13'h0400, 24, 33, "R8");
        lock_en = 0;

        run_cmd(13'h0300, 0, 0, "R9");

        // R10: abort discards bytes, later stop writes nothing
        cur_tag = "R10";
        @(posedge clk); #1 ld_begin = 1; ld_addr = 13'h0500;
        @(posedge clk); #1 ld_begin = 0; ld_valid = 1; ld_data = 8'hA5;
        @(posedge clk); #1 ld_valid = 0; ld_abort = 1;
        @(posedge clk); #1 ld_abort = 0; ld_stop = 1;
        @(posedge clk); #1 ld_stop = 0;
        measure_busy(nb);
        chk(nb == 0, "R10 busy after abort", 64'(nb), 0);

        // R11: load inputs during a flush are ignored
        cur_tag = "R11";
        begin
            wr_item_t it;
            it.addr = 13'h0050; it.be = 8'h04; it.data = 64'h0000_0000_003C_0000;
            exp_q.push_back(it);
        end
        @(posedge clk); #1 ld_begin = 1; ld_addr = 13'h0052;
        @(posedge clk); #1 ld_begin = 0; ld_valid = 1; ld_data = 8'h3C;
        @(posedge clk); #1 ld_valid = 0; ld_stop = 1;
        @(posedge clk); #1 ld_stop = 0;
        @(posedge clk); #1 ld_begin = 1; ld_addr = 13'h0700;
        @(posedge clk); #1 ld_begin = 0; ld_valid = 1; ld_data = 8'hEE;
        @(posedge clk); #1 ld_data = 8'hEF;
        @(posedge clk); #1 ld_valid = 0; ld_stop = 1;
        @(posedge clk); #1 ld_stop = 0;
        measure_busy(nb);
        nb = 0;
        repeat (40) begin
            @(negedge clk);
            if (busy) nb++;
        end
        chk(nb == 0, "R11 busy after ignored stop", 64'(nb), 0);
        chk(exp_q.size() == 0, "R11 write missing", 64'(exp_q.size()), 0);

        // R12: flags cleared, new command writes only its own byte
        run_cmd(13'h0401, 1, 90, "R12");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule